// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer for a 10-bit successive-approximation converter. Software reaches it through a small byte-wide register port. The control fields cover enable, start/busy, input channel, reference choice and result justification. A separate register selects the conversion clock, and a third holds a per-pin analog mask. The sample-and-hold, the trial DAC, the comparator and the pad drivers sit outside the block. They connect through ports: a trial code goes out, a single comparator bit comes back, and mux selects go to the analog front end.

When software sets the start bit while the block is enabled, the controller latches the clock choice and runs a fixed sequence of 11 conversion-clock periods. The conversion clock is a one-cycle enable pulse. It is either the system clock divided by 2, 4, 8, 16, 32 or 64, or an enable that an internal RC oscillator supplies on `rc_tick_i`. The first period is acquisition, with the sample-and-hold tracking. Each of the next ten periods resolves one bit, starting from the most significant. At the end, the block stores the result, clears the start bit and pulses `done_o`. Software reads the result as two bytes packed right- or left-justified.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, `done_o`, `sample_o` and `dac_code_o` are 0, and `dig_in_en_o` is all ones.
- R2: Address 0 is control: bit0 enable, bit1 start/busy, bits4:2 channel, bit5 reference select, bit6 reads 0, bit7 right-justify. Address 1 bits2:0 hold the clock select. Address 2 holds the analog pin mask. Address 3 is the result high byte and address 4 the result low byte. Other addresses read 0. Writes occur when `wr_en_i` is high at a clock edge, and reads are combinational on `addr_i`.
- R3: Clock select values 0 to 5 produce one conversion tick every 2^(sel+1) system cycles, counted from the first cycle of the conversion. Values 6 and 7 use each cycle in which `rc_tick_i` is high.
- R4: A conversion ends after exactly 11 ticks. `done_o` is high for one cycle, in the cycle after the 11th tick, and the start bit reads 0 from that cycle on.
- R5: During the first period `sample_o` is 1 and `dac_code_o` is 0. In period k (1 to 10), `dac_code_o` equals the bits kept so far with bit 10-k set. That bit is kept when `cmp_i` is 1 at the tick that ends the period. `cmp_i` = 1 means input is at or above the trial code.
- R6: The result registers change only in the cycle that ends a conversion.
- R7: Writing control with start=0 or enable=0 during a conversion aborts it. No done pulse follows and the result is unchanged.
- R8: A clock-select write during a conversion does not change that conversion's timing. It applies to the next conversion.
- R9: With right-justify=1, high = {000000, r[9:8]} and low = r[7:0]. With right-justify=0, high = r[9:2] and low = {r[1:0], 000000}.
- R10: `chan_sel_o` follows the channel field, and `ref_sel_o` follows the reference bit (1 = external reference pin, 0 = supply).
- R11: `dig_in_en_o` is the bitwise inverse of the analog pin mask.
- R12: A control write that sets start with enable=0 does not start a conversion, and the start bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| rc_tick_i | input | 1 | Enable pulses from internal RC clock |
| cmp_i | input | 1 | Comparator: 1 when input >= trial code |
| dac_code_o | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sample-and-hold tracking during acquisition |
| chan_sel_o | output | 3 | Analog input mux select |
| ref_sel_o | output | 1 | Reference mux select |
| dig_in_en_o | output | 8 | Digital input buffer enables per pin |
| done_o | output | 1 | One-cycle conversion-complete pulse |

## Verification
The bench runs a cycle-level model of the tick count and the trial code. It checks `dac_code_o`, `sample_o`, `done_o` and the held result on every cycle of a conversion, for the smallest and largest dividers and for RC ticks on an irregular period.

Several errors would show up here:
- A divider off by one would move `done_o` by eleven cycles or more.
- Sampling the comparator one period late, or keeping a bit on the wrong polarity, would corrupt the trial codes and the final result. The bench exercises both with full-scale, zero and mid-range inputs.
- A clock-select change leaking into a running conversion would change its length.
- An abort that still wrote the result or pulsed `done_o` would be seen at the ports.
- Swapped justification packing would show in the two result bytes.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_CLK    = 3'd1;
  localparam logic [2:0] A_PINS   = 3'd2;
  localparam logic [2:0] A_RES_HI = 3'd3;
  localparam logic [2:0] A_RES_LO = 3'd4;

  localparam int C_EN  = 0;
  localparam int C_GO  = 1;
  localparam int C_CH  = 2;
  localparam int C_REF = 5;
  localparam int C_RJ  = 7;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
  import adc_pkg::*;
#(
  parameter int NUM_DIV = 6,
  localparam int CNT_W  = NUM_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rc_tick_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             is_rc;

  assign is_rc = (int'(sel_i) >= NUM_DIV);
  assign lim   = CNT_W'((32'd2 << sel_i) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || is_rc)     cnt_q <= '0;
    else if (cnt_q == lim)        cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (is_rc ? rc_tick_i : (cnt_q == lim));

  // R3
  div_tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !is_rc) |=> !tick_o);
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES_W  = 10,
  localparam int PER_W = $clog2(RES_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam logic [PER_W-1:0] LAST = PER_W'(RES_W);

  logic [PER_W-1:0] per_q;
  logic [RES_W-1:0] sar_q;
  logic [RES_W-1:0] trial_bit;

  // period k>=1 tries bit RES_W-k
  always_comb begin
    trial_bit = '0;
    if (per_q != '0) trial_bit = RES_W'(1) << (RES_W - int'(per_q));
  end

  assign dac_o    = run_i ? (sar_q | trial_bit) : '0;
  assign sample_o = run_i && (per_q == '0);
  assign result_o = sar_q | (cmp_i ? trial_bit : '0);
  assign done_o   = run_i && tick_i && (per_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      sar_q <= '0;
    end else if (!run_i) begin
      per_q <= '0;
      sar_q <= '0;
    end else if (tick_i) begin
      if (per_q == LAST) begin
        per_q <= '0;
        sar_q <= '0;
      end else begin
        per_q <= per_q + 1'b1;
        sar_q <= result_o;
      end
    end
  end

  // R4
  per_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q <= LAST);

  // R5
  sar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> (!run_i || $stable(sar_q)));
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              rjust_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam int FULL_W = 2 * BYTE_W;

  logic [FULL_W-1:0] right_w;
  logic [FULL_W-1:0] left_w;

  assign right_w = FULL_W'(res_i);
  assign left_w  = {res_i, {(FULL_W-RES_W){1'b0}}};

  assign hi_o = rjust_i ? right_w[FULL_W-1:BYTE_W] : left_w[FULL_W-1:BYTE_W];
  assign lo_o = rjust_i ? right_w[BYTE_W-1:0]      : left_w[BYTE_W-1:0];
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import adc_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int NUM_CH   = 8,
  parameter int NUM_PINS = 8,
  parameter int NUM_DIV  = 6,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  input  logic                rc_tick_i,
  input  logic                cmp_i,
  output logic [RES_W-1:0]    dac_code_o,
  output logic                sample_o,
  output logic [CH_W-1:0]     chan_sel_o,
  output logic                ref_sel_o,
  output logic [NUM_PINS-1:0] dig_in_en_o,
  output logic                done_o
);
  logic                en_q, go_q, ref_q, rjust_q, done_q;
  logic [CH_W-1:0]     chan_q;
  logic [SEL_W-1:0]    clk_sel_q, clk_act_q;
  logic [NUM_PINS-1:0] pins_q;
  logic [RES_W-1:0]    res_q;

  logic                wr_ctrl, wr_clk, wr_pins, start;
  logic                tick, seq_done;
  logic [RES_W-1:0]    seq_res;
  logic [BYTE_W-1:0]   res_hi, res_lo;
  logic                unused_wbit;

  assign unused_wbit = wdata_i[6];

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_clk  = wr_en_i && (addr_i == A_CLK);
  assign wr_pins = wr_en_i && (addr_i == A_PINS);
  assign start   = wr_ctrl && wdata_i[C_EN] && wdata_i[C_GO] && !go_q && !seq_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      go_q      <= 1'b0;
      ref_q     <= 1'b0;
      rjust_q   <= 1'b0;
      chan_q    <= '0;
      clk_sel_q <= '0;
      clk_act_q <= '0;
      pins_q    <= '0;
      res_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= wdata_i[C_EN];
        chan_q  <= wdata_i[C_CH +: CH_W];
        ref_q   <= wdata_i[C_REF];
        rjust_q <= wdata_i[C_RJ];
      end
      // completion wins over a same-cycle write of the start bit
      if (seq_done)     go_q <= 1'b0;
      else if (wr_ctrl) go_q <= wdata_i[C_EN] && wdata_i[C_GO];
      if (start)   clk_act_q <= clk_sel_q;
      if (wr_clk)  clk_sel_q <= wdata_i[SEL_W-1:0];
      if (wr_pins) pins_q    <= wdata_i[NUM_PINS-1:0];
      if (seq_done) res_q    <= seq_res;
      done_q <= seq_done;
    end
  end

  adc_tick_gen #(.NUM_DIV(NUM_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (go_q),
    .sel_i     (clk_act_q),
    .rc_tick_i (rc_tick_i),
    .tick_o    (tick)
  );

  adc_sar_seq #(.RES_W(RES_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (go_q),
    .tick_i   (tick),
    .cmp_i    (cmp_i),
    .dac_o    (dac_code_o),
    .sample_o (sample_o),
    .done_o   (seq_done),
    .result_o (seq_res)
  );

  adc_result_fmt #(.RES_W(RES_W)) u_fmt (
    .res_i   (res_q),
    .rjust_i (rjust_q),
    .hi_o    (res_hi),
    .lo_o    (res_lo)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rdata_o = {rjust_q, 1'b0, ref_q, chan_q, go_q, en_q};
      A_CLK:    rdata_o = BYTE_W'(clk_sel_q);
      A_PINS:   rdata_o = BYTE_W'(pins_q);
      A_RES_HI: rdata_o = res_hi;
      A_RES_LO: rdata_o = res_lo;
      default:  rdata_o = '0;
    endcase
  end

  assign chan_sel_o  = chan_q;
  assign ref_sel_o   = ref_q;
  assign dig_in_en_o = ~pins_q;
  assign done_o      = done_q;

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_clears_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !go_q);

  // R6
  res_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_done |=> $stable(res_q));

  // R12
  go_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !go_q);
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rc_tick_i = 1'b0;
  logic       cmp_i;
  logic [9:0] dac_code_o;
  logic       sample_o;
  logic [2:0] chan_sel_o;
  logic       ref_sel_o;
  logic [7:0] dig_in_en_o;
  logic       done_o;

  int vin = 0;
  int rc_cnt = 0;
  int checks = 0;
  int errors = 0;
  int last_res = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // irregular RC enable: one pulse every 5 cycles
  always @(posedge clk) begin
    rc_cnt    <= (rc_cnt == 4) ? 0 : rc_cnt + 1;
    rc_tick_i <= (rc_cnt == 4);
  end

  assign cmp_i = (vin >= int'(dac_code_o));

  sar_adc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rc_tick_i(rc_tick_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .sample_o(sample_o), .chan_sel_o(chan_sel_o),
    .ref_sel_o(ref_sel_o), .dig_in_en_o(dig_in_en_o), .done_o(done_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 3'(a); wdata_i = 8'(d);
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    addr_i = 3'(a); #1;
    v = int'(rdata_o);
  endtask

  function automatic int hi_of(int r, bit rj);
    return rj ? (r >> 8) : (r >> 2);
  endfunction

  function automatic int lo_of(int r, bit rj);
    return rj ? (r & 255) : ((r & 3) << 6);
  endfunction

  task automatic run_conv(int sel, bit sel_wr, int v, bit rj, int poke_cyc, int poke_sel);
    int n, ticks, sar, trial, old_lo, rv, expv;
    if (sel_wr) wr(1, sel);
    n = 2 << sel;
    vin = v;
    old_lo = lo_of(last_res, rj);
    wr(0, (rj ? 8'h80 : 8'h00) | 8'h03);
    addr_i = 3'd4;
    ticks = 0; sar = 0;
    for (int c = 0; c < 20000; c++) begin
      bit tk;
      @(negedge clk); #1;
      if (c == poke_cyc + 1) wr_en_i = 1'b0;
      if (ticks == 11) begin
        chk("R4 done pulse at end", int'(done_o), 1);
        chk("R6 result lo updated", int'(rdata_o), lo_of(sar, rj));
        break;
      end
      chk("R4 no early done", int'(done_o), 0);
      chk("R5 sample window", int'(sample_o), (ticks == 0) ? 1 : 0);
      trial = (ticks == 0) ? 0 : (sar | (1 << (10 - ticks)));
      chk("R5 trial code", int'(dac_code_o), trial);
      if (c != poke_cyc + 1) chk("R6 result held", int'(rdata_o), old_lo);
      tk = (sel >= 6) ? rc_tick_i : (((c + 1) % n) == 0);
      if (tk) begin
        if (ticks >= 1 && v >= trial) sar = trial;
        ticks++;
      end
      if (c == poke_cyc) begin
        wr_en_i = 1'b1; addr_i = 3'd1; wdata_i = 8'(poke_sel);
      end else if (c == poke_cyc + 1) begin
        addr_i = 3'd4;
      end
    end
    expv = (v > 1023) ? 1023 : v;
    chk("R5 final code", sar, expv);
    last_res = sar;
    rd(0, rv);
    chk("R4 start bit cleared", (rv >> 1) & 1, 0);
    chk("R4 done one cycle", int'(done_o), 0);
    rd(3, rv); chk("R9 high byte", rv, hi_of(sar, rj));
    rd(4, rv); chk("R9 low byte", rv, lo_of(sar, rj));
  endtask

  task automatic abort_conv(bit by_en);
    int rv, old_hi, old_lo;
    wr(1, 0);
    vin = 900;
    old_hi = hi_of(last_res, 1'b1);
    old_lo = lo_of(last_res, 1'b1);
    wr(0, 8'h83);
    repeat (5) @(negedge clk);
    wr(0, by_en ? 8'h82 : 8'h81);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk); #1;
      chk("R7 no done after abort", int'(done_o), 0);
      chk("R7 idle after abort", int'(sample_o) + int'(dac_code_o), 0);
    end
    rd(0, rv); chk("R7 start bit cleared", (rv >> 1) & 1, 0);
    rd(3, rv); chk("R7 high byte kept", rv, old_hi);
    rd(4, rv); chk("R7 low byte kept", rv, old_lo);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rv;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, rv); chk("R1 register reset", rv, 0);
    end
    chk("R1 done reset", int'(done_o), 0);
    chk("R1 sample reset", int'(sample_o), 0);
    chk("R1 dac reset", int'(dac_code_o), 0);
    chk("R1 buffers enabled", int'(dig_in_en_o), 255);

    // R2 R10 R11 register map and outputs
    wr(0, 8'hB5);
    rd(0, rv); chk("R2 control readback", rv, 8'hB5);
    chk("R10 channel select", int'(chan_sel_o), 5);
    chk("R10 reference select", int'(ref_sel_o), 1);
    wr(0, 8'h00);
    chk("R10 reference select supply", int'(ref_sel_o), 0);
    wr(1, 3); rd(1, rv); chk("R2 clock select readback", rv, 3);
    wr(2, 8'hA5); rd(2, rv); chk("R2 pin mask readback", rv, 8'hA5);
    chk("R11 buffer enables", int'(dig_in_en_o), 8'h5A);
    rd(5, rv); chk("R2 unmapped reads 0", rv, 0);

    // R3 R5 R9 conversions under several dividers and inputs
    run_conv(0, 1'b1, 727, 1'b1, -10, 0);
    rd(3, rv); chk("R9 right high 727", rv, 8'h02);
    rd(4, rv); chk("R9 right low 727", rv, 8'hD7);
    wr(0, 8'h01);
    rd(3, rv); chk("R9 left high 727", rv, 8'hB5);
    rd(4, rv); chk("R9 left low 727", rv, 8'hC0);
    run_conv(2, 1'b1, 0, 1'b1, -10, 0);
    run_conv(1, 1'b1, 1023, 1'b0, -10, 0);
    run_conv(6, 1'b1, 512, 1'b1, -10, 0);
    run_conv(7, 1'b1, 2000, 1'b0, -10, 0);
    run_conv(5, 1'b1, 300, 1'b1, -10, 0);

    // R8 clock select written mid-conversion
    run_conv(0, 1'b1, 100, 1'b1, 3, 5);
    rd(1, rv); chk("R8 new select stored", rv, 5);
    run_conv(5, 1'b0, 641, 1'b1, -10, 0);

    // R7 aborts
    abort_conv(1'b0);
    abort_conv(1'b1);

    // R12 start without enable
    wr(0, 8'h02);
    rd(0, rv); chk("R12 start ignored when disabled", rv, 0);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); #1;
      chk("R12 no sampling when disabled", int'(sample_o), 0);
      chk("R12 no done when disabled", int'(done_o), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule